// File: doc/BRIEF.md
# Latched Serial Register Port

This block is a write-only control port. An external controller shifts 16-bit words into it over a serial clock line and a serial data line. After the last bit it raises a separate latch line. On that rising edge the block checks the word and commits it to one of three 14-bit configuration registers: the left volume, the right volume or a general control word. The three register values are held on output buses for the rest of the chip. A one-cycle strobe, together with the index of the register that was written, marks each commit.

All three serial lines are treated as asynchronous. They pass through a synchronizer chain into the system clock domain, and their edges are detected there. The serial clock must therefore run well below the system clock. A word is committed only when exactly 16 bits arrived since the previous latch edge and its address field names a real register. A wrong bit count raises a one-cycle error pulse. The reserved address is dropped without any effect.

Top module: `sctl_port`

## Requirements
- R1: While reset is asserted and after it is released, both volume outputs read 0x3FFF, the control output reads 0x0000, and the strobe and error pulses are low.
- R2: A data bit is captured on each rising edge of the serial clock, most significant bit first. Bits [15:2] of a 16-bit word are the payload and bits [1:0] are the address.
- R3: Address 2'b00 writes the payload to the left volume output.
- R4: Address 2'b01 writes the payload to the right volume output.
- R5: Address 2'b10 writes the payload to the control output.
- R6: Address 2'b11 changes no output and raises neither the strobe nor the error pulse.
- R7: A latch rising edge after a bit count other than 16 (fewer or more) changes no output and raises the error pulse for exactly one cycle.
- R8: Each latch rising edge clears the bit count, so a correct word that follows a rejected one is committed normally.
- R9: Every commit raises the strobe for exactly one cycle, with the select output equal to the address written, and never together with the error pulse.
- R10: A commit changes only the addressed register. The other two keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock; data is taken on its rising edge |
| ser_dat | input | 1 | Serial data, most significant bit first |
| ser_latch | input | 1 | Commit line; its rising edge ends a word |
| vol_left | output | 14 | Left volume register |
| vol_right | output | 14 | Right volume register |
| ctrl_word | output | 14 | Control register |
| upd_pulse | output | 1 | One-cycle strobe on each commit |
| upd_sel | output | 2 | Index of the register committed with the strobe |
| frame_err | output | 1 | One-cycle pulse on a latch after a wrong bit count |

## Verification
The assertions assume that every level on the serial lines lasts long enough to pass the synchronizer, so each serial clock edge and each latch edge is seen exactly once. They also assume that the data line does not change near the rising edge of the serial clock, and that the latch does not rise in the same sampled cycle as a serial clock edge. The stimulus changes data only while the serial clock is low and holds every level for four system clocks. It raises the latch only after the serial clock has been low for several cycles, which keeps it inside those assumptions.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_LEFT  = 2'b00,
        SEL_RIGHT = 2'b01,
        SEL_CTRL  = 2'b10,
        SEL_NONE  = 2'b11
    } sel_e;
endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.chain[STAGES-1];
endmodule

// File: rtl/sctl_shift.sv
module sctl_shift #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_lvl,
    input  logic              sdat_lvl,
    input  logic              latch_lvl,
    output logic [WORD_W-1:0] word_o,
    output logic              frame_ok,
    output logic              frame_bad
);
    localparam int CNT_W = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(WORD_W + 1);

    typedef struct packed {
        logic              sclk_prev;
        logic              latch_prev;
        logic [WORD_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
    } shift_t;

    shift_t st_d, st_q;
    logic   sclk_rise, latch_rise;

    always_comb begin
        sclk_rise  = sclk_lvl  & ~st_q.sclk_prev;
        latch_rise = latch_lvl & ~st_q.latch_prev;
        st_d            = st_q;
        st_d.sclk_prev  = sclk_lvl;
        st_d.latch_prev = latch_lvl;
        if (latch_rise) begin
            st_d.cnt = '0;
        end else if (sclk_rise) begin
            st_d.shreg = {st_q.shreg[WORD_W-2:0], sdat_lvl};
            if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
        end
        frame_ok  = latch_rise && (st_q.cnt == CNT_FULL);
        frame_bad = latch_rise && (st_q.cnt != CNT_FULL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o = st_q.shreg;

    // R2: the shift register moves only after a sampled serial clock high level
    assert_shift_on_sclk_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.shreg != $past(st_q.shreg)) |-> $past(sclk_lvl));

    // R8: the bit count is zero in the cycle after a latch edge
    assert_cnt_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ok || frame_bad) |=> (st_q.cnt == '0));
endmodule

// File: rtl/sctl_regs.sv
module sctl_regs
    import sctl_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [WORD_W-1:0]        word_i,
    input  logic                     frame_ok,
    input  logic                     frame_bad,
    output logic [WORD_W-ADDR_W-1:0] left_o,
    output logic [WORD_W-ADDR_W-1:0] right_o,
    output logic [WORD_W-ADDR_W-1:0] ctrl_o,
    output logic                     upd_o,
    output logic [ADDR_W-1:0]        sel_o,
    output logic                     err_o
);
    localparam int PAY_W = WORD_W - ADDR_W;

    typedef struct packed {
        logic [PAY_W-1:0] left;
        logic [PAY_W-1:0] right;
        logic [PAY_W-1:0] ctrl;
        logic             upd;
        sel_e             sel;
        logic             err;
    } regs_t;

    regs_t            st_d, st_q;
    sel_e             addr;
    logic [PAY_W-1:0] payload;

    always_comb begin
        addr    = sel_e'(word_i[ADDR_W-1:0]);
        payload = word_i[WORD_W-1:ADDR_W];
        st_d     = st_q;
        st_d.upd = 1'b0;
        st_d.err = frame_bad;
        if (frame_ok) begin
            case (addr)
                SEL_LEFT:  begin st_d.left  = payload; st_d.upd = 1'b1; st_d.sel = addr; end
                SEL_RIGHT: begin st_d.right = payload; st_d.upd = 1'b1; st_d.sel = addr; end
                SEL_CTRL:  begin st_d.ctrl  = payload; st_d.upd = 1'b1; st_d.sel = addr; end
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.left  <= '1;
            st_q.right <= '1;
            st_q.ctrl  <= '0;
            st_q.upd   <= 1'b0;
            st_q.sel   <= SEL_LEFT;
            st_q.err   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign left_o  = st_q.left;
    assign right_o = st_q.right;
    assign ctrl_o  = st_q.ctrl;
    assign upd_o   = st_q.upd;
    assign sel_o   = st_q.sel;
    assign err_o   = st_q.err;

    assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.upd |=> !st_q.upd);

    assert_strobe_no_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |-> !st_q.upd);

    assert_sel_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.upd |-> (st_q.sel != SEL_NONE));

    assert_left_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.left) |-> (st_q.upd && st_q.sel == SEL_LEFT));

    assert_right_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.right) |-> (st_q.upd && st_q.sel == SEL_RIGHT));

    assert_ctrl_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.ctrl) |-> (st_q.upd && st_q.sel == SEL_CTRL));
endmodule

// File: rtl/sctl_port.sv
module sctl_port
    import sctl_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ser_clk,
    input  logic                     ser_dat,
    input  logic                     ser_latch,
    output logic [WORD_W-ADDR_W-1:0] vol_left,
    output logic [WORD_W-ADDR_W-1:0] vol_right,
    output logic [WORD_W-ADDR_W-1:0] ctrl_word,
    output logic                     upd_pulse,
    output logic [ADDR_W-1:0]        upd_sel,
    output logic                     frame_err
);
    localparam int LINES = 3;

    logic [LINES-1:0]  lines_sync;
    logic [WORD_W-1:0] word;
    logic              frame_ok, frame_bad;

    sctl_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ser_latch, ser_clk, ser_dat}),
        .dout (lines_sync)
    );

    sctl_shift #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_lvl (lines_sync[1]),
        .sdat_lvl (lines_sync[0]),
        .latch_lvl(lines_sync[2]),
        .word_o   (word),
        .frame_ok (frame_ok),
        .frame_bad(frame_bad)
    );

    sctl_regs #(.WORD_W(WORD_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_i   (word),
        .frame_ok (frame_ok),
        .frame_bad(frame_bad),
        .left_o   (vol_left),
        .right_o  (vol_right),
        .ctrl_o   (ctrl_word),
        .upd_o    (upd_pulse),
        .sel_o    (upd_sel),
        .err_o    (frame_err)
    );

    // R7: a rejected frame is reported one cycle after the shifter flags it
    assert_bad_reported_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_bad |=> (frame_err && !upd_pulse));
endmodule

// File: tb/sim_sctl_port.sv
`timescale 1ns/1ps
module sim_sctl_port;
    localparam int HOLD = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0, ser_dat = 1'b0, ser_latch = 1'b0;
    logic [13:0] vol_left, vol_right, ctrl_word;
    logic        upd_pulse, frame_err;
    logic [1:0]  upd_sel;

    int checks = 0, errors = 0;
    int upd_cnt = 0, err_cnt = 0, run = 0, max_run = 0, both = 0;
    logic [1:0] last_sel = 2'b00;
    bit done = 0;

    always #2.5 clk = ~clk;

    sctl_port u0 (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_latch(ser_latch), .vol_left(vol_left), .vol_right(vol_right),
        .ctrl_word(ctrl_word), .upd_pulse(upd_pulse), .upd_sel(upd_sel),
        .frame_err(frame_err)
    );

    always @(negedge clk) begin
        if (upd_pulse) begin
            upd_cnt++; last_sel = upd_sel; run++;
            if (run > max_run) max_run = run;
        end else run = 0;
        if (frame_err) err_cnt++;
        if (upd_pulse && frame_err) both++;
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(logic [31:0] val, int nbits);
        for (int i = nbits - 1; i >= 0; i--) begin
            ser_dat = val[i];
            wait_n(HOLD);
            ser_clk = 1'b1;
            wait_n(HOLD);
            ser_clk = 1'b0;
        end
        wait_n(HOLD);
        ser_latch = 1'b1;
        wait_n(HOLD);
        ser_latch = 1'b0;
        wait_n(10);
    endtask

    task automatic t_reset();
        chk("R1 left", 32'(vol_left), 32'h3FFF);
        chk("R1 right", 32'(vol_right), 32'h3FFF);
        chk("R1 ctrl", 32'(ctrl_word), 32'h0);
        chk("R1 strobe count", 32'(upd_cnt), 0);
        chk("R1 error count", 32'(err_cnt), 0);
    endtask

    task automatic t_write(logic [13:0] pay, logic [1:0] a, string tag);
        int u0c = upd_cnt, e0 = err_cnt;
        logic [13:0] l0 = vol_left, r0 = vol_right, c0 = ctrl_word;
        send({16'h0, pay, a}, 16);
        chk({tag, " left"},  32'(vol_left),  32'(a == 2'b00 ? pay : l0));
        chk({tag, " right"}, 32'(vol_right), 32'(a == 2'b01 ? pay : r0));
        chk({tag, " ctrl"},  32'(ctrl_word), 32'(a == 2'b10 ? pay : c0));
        chk({tag, " R9 strobes"}, 32'(upd_cnt - u0c), (a == 2'b11) ? 0 : 1);
        chk({tag, " error pulses"}, 32'(err_cnt - e0), 0);
        if (a != 2'b11) chk({tag, " R9 select"}, 32'(last_sel), 32'(a));
    endtask

    task automatic t_bad_count(int nbits, string tag);
        int u0c = upd_cnt, e0 = err_cnt;
        logic [13:0] l0 = vol_left, r0 = vol_right, c0 = ctrl_word;
        send(32'h0001_5554, nbits);
        chk({tag, " R7 left"},  32'(vol_left),  32'(l0));
        chk({tag, " R7 right"}, 32'(vol_right), 32'(r0));
        chk({tag, " R7 ctrl"},  32'(ctrl_word), 32'(c0));
        chk({tag, " R7 error pulses"}, 32'(err_cnt - e0), 1);
        chk({tag, " R7 strobes"}, 32'(upd_cnt - u0c), 0);
    endtask

    initial begin
        wait_n(5);
        t_reset();
        rst_n = 1'b1;
        wait_n(5);
        t_reset();
        t_write(14'h1234, 2'b00, "R3 R2 R10 left");
        t_write(14'h2AAA, 2'b01, "R4 R10 right");
        t_write(14'h0155, 2'b10, "R5 R10 ctrl");
        t_write(14'h2001, 2'b00, "R2 msb-first left");
        t_write(14'h3C3C, 2'b11, "R6 reserved");
        t_bad_count(15, "short");
        t_bad_count(17, "long");
        t_bad_count(0, "empty");
        t_write(14'h0777, 2'b01, "R8 after reject");
        chk("R9 strobe width", 32'(max_run), 1);
        chk("R9 strobe with error", 32'(both), 0);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule